// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block chooses, for each of six counter channels, which signal acts as that channel's count clock and which acts as its gate. The six channels sit in one group made of two counter chips of three channels each. A bus master writes one byte at a time. The byte goes either to the clock-select register or to the gate-select register of the group. It carries a chip index, a channel index and a source number, and the block keeps that source for the addressed channel until it is written again.

Count clocks leave the block as single-cycle enable strobes in the reference clock domain. The reference clock runs at 20 MHz. An internal divider chain produces strobes at 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz. The reference rate itself, 20 MHz, can also be selected, but only while extended mode is on. Each channel can also take a rising edge on its own external clock pin. Gates leave the block as registered levels. A gate can be held high permanently, or it can follow the channel's own external gate pin. Source numbers with no function assigned give a constant low.

Top module: `srcx_router`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, every channel uses clock source 0 and gate source 0. All gate outputs are therefore high, and a clock strobe appears only on a pin edge.
- R2: A write addresses channel index = 3*chip + channel. The chip is byte bit 5 and the channel is byte bits 4:3. Only that channel's stored selection changes.
- R3: A write whose channel field (bits 4:3) equals 3 changes no channel's selection.
- R4: With `enh_en` high, the stored source number is {byte[7:6], byte[2:0]}, giving values 0 to 31.
- R5: With `enh_en` low, byte bits 7:6 are taken as zero, so the stored source lies in 0 to 7.
- R6: Clock source 0 gives a one-cycle strobe in the first cycle after the channel's `ext_clk_i` bit is sampled high where it was low in the cycle before.
- R7: Clock sources 1, 2, 3, 4 and 5 give one-cycle strobes every 2, 20, 200, 2000 and 20000 reference cycles.
- R8: Clock source 11 gives a strobe in every cycle while `enh_en` is high. It gives no strobe while `enh_en` is low.
- R9: Gate source 0 drives the gate high. Gate source 1 drives the channel's `ext_gate_i` bit, delayed by one cycle.
- R10: Clock sources 6 to 10 and 12 to 31 give no strobe, and gate sources 2 to 31 drive the gate low.
- R11: A clock-select write leaves every gate selection unchanged, and a gate-select write leaves every clock selection unchanged.
- R12: A write changes a channel's outputs starting in the second cycle after the write cycle. The first cycle after the write still shows the old selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enh_en | input | 1 | Extended mode: 5-bit sources and the reference-rate source |
| wr_en | input | 1 | Write strobe for a select byte |
| wr_is_gate | input | 1 | 1 selects the gate-select register, 0 the clock-select register |
| wr_byte | input | 8 | Select byte: source[4:3], chip, channel, source[2:0] |
| ext_clk_i | input | 6 | Per-channel external clock pins, synchronous levels |
| ext_gate_i | input | 6 | Per-channel external gate pins, synchronous levels |
| cnt_clk_en_o | output | 6 | Per-channel count-enable strobe |
| cnt_gate_o | output | 6 | Per-channel gate level |

## Verification
The assertions assume the following about the inputs. The external pins are already synchronous to the reference clock. `wr_byte` and `wr_is_gate` are meaningful whenever `wr_en` is high. `enh_en` is a level that the unit reading the outputs samples in the same cycle as the strobe. The stimulus changes every input only on the falling clock edge, and it holds `wr_en` for exactly one cycle per write. That keeps every write, pin edge and mode change one clean cycle wide, and it places each expected output change in a cycle the bench can count exactly.

// File: rtl/srcx_pkg.sv
package srcx_pkg;

    localparam int SRC_W = 5;
    typedef logic [SRC_W-1:0] src_t;

    // clock source codes; the divided clocks occupy a contiguous run
    localparam src_t CSRC_PIN       = 5'd0;
    localparam src_t CSRC_DIV_FIRST = 5'd1;
    localparam src_t CSRC_REF       = 5'd11;

    // gate source codes
    localparam src_t GSRC_HIGH = 5'd0;
    localparam src_t GSRC_PIN  = 5'd1;

    // select byte field positions
    localparam int FLD_SRC_LO_W = 3;
    localparam int FLD_CHAN_LSB = 3;
    localparam int FLD_CHIP_BIT = 5;
    localparam int FLD_SRC_HI   = 6;

    typedef struct packed {
        logic       chip;
        logic [1:0] chan;
        src_t       src;
    } sel_fields_t;

    function automatic sel_fields_t unpack_sel(input logic [7:0] b, input logic ext_mode);
        sel_fields_t f;
        f.chip = b[FLD_CHIP_BIT];
        f.chan = b[FLD_CHAN_LSB +: 2];
        f.src  = {(ext_mode ? b[FLD_SRC_HI +: 2] : 2'b00), b[FLD_SRC_LO_W-1:0]};
        return f;
    endfunction

endpackage

// File: rtl/srcx_divider.sv
module srcx_divider #(
    parameter int PRE_DIV   = 2,
    parameter int DEC_RATIO = 10,
    parameter int NUM_DEC   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [NUM_DEC:0] stb
);
    localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam int DEC_W = $clog2(DEC_RATIO);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
    localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(DEC_RATIO - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (pre_q == PRE_LAST)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    assign stb[0] = (pre_q == PRE_LAST);

    // each decade advances on the strobe of the stage below it
    for (genvar k = 1; k <= NUM_DEC; k++) begin : g_dec
        logic [DEC_W-1:0] dec_q;

        always_ff @(posedge clk) begin
            if (!rst_n)
                dec_q <= '0;
            else if (stb[k-1])
                dec_q <= (dec_q == DEC_LAST) ? '0 : dec_q + 1'b1;
        end

        assign stb[k] = stb[k-1] && (dec_q == DEC_LAST);
    end

endmodule

// File: rtl/srcx_wr_decode.sv
module srcx_wr_decode
    import srcx_pkg::*;
#(
    parameter int CHIPS       = 2,
    parameter int CH_PER_CHIP = 3
) (
    input  logic                          wr_en,
    input  logic                          wr_is_gate,
    input  logic [7:0]                    wr_byte,
    input  logic                          enh_en,
    output logic [CHIPS*CH_PER_CHIP-1:0]  clk_we,
    output logic [CHIPS*CH_PER_CHIP-1:0]  gate_we,
    output src_t                          wr_src
);
    sel_fields_t fld;

    assign fld    = unpack_sel(wr_byte, enh_en);
    assign wr_src = fld.src;

    for (genvar c = 0; c < CHIPS; c++) begin : g_chip
        for (genvar k = 0; k < CH_PER_CHIP; k++) begin : g_ch
            logic hit;
            assign hit = wr_en && (fld.chip == 1'(c)) && (fld.chan == 2'(k));
            assign clk_we[c*CH_PER_CHIP + k]  = hit && !wr_is_gate;
            assign gate_we[c*CH_PER_CHIP + k] = hit && wr_is_gate;
        end
    end

endmodule

// File: rtl/srcx_chan.sv
module srcx_chan
    import srcx_pkg::*;
#(
    parameter int NUM_DIV = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enh_en,
    input  logic               clk_we,
    input  logic               gate_we,
    input  src_t               wr_src,
    input  logic [NUM_DIV-1:0] div_stb,
    input  logic               ext_clk,
    input  logic               ext_gate,
    output logic               clk_en,
    output logic               gate,
    output src_t               clk_sel,
    output src_t               gate_sel
);
    logic ext_clk_q;
    logic pin_rise;
    logic clk_nxt;
    logic gate_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel  <= CSRC_PIN;
            gate_sel <= GSRC_HIGH;
        end else begin
            if (clk_we)
                clk_sel <= wr_src;
            if (gate_we)
                gate_sel <= wr_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_clk_q <= 1'b0;
        else
            ext_clk_q <= ext_clk;
    end

    assign pin_rise = ext_clk && !ext_clk_q;

    always_comb begin
        clk_nxt = 1'b0;
        if (clk_sel == CSRC_PIN)
            clk_nxt = pin_rise;
        else if (clk_sel == CSRC_REF)
            clk_nxt = enh_en;
        for (int d = 0; d < NUM_DIV; d++) begin
            if (clk_sel == src_t'(int'(CSRC_DIV_FIRST) + d))
                clk_nxt = div_stb[d];
        end
    end

    always_comb begin
        unique case (gate_sel)
            GSRC_HIGH: gate_nxt = 1'b1;
            GSRC_PIN:  gate_nxt = ext_gate;
            default:   gate_nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en <= 1'b0;
            gate   <= 1'b1;
        end else begin
            clk_en <= clk_nxt;
            gate   <= gate_nxt;
        end
    end

endmodule

// File: rtl/srcx_router.sv
module srcx_router
    import srcx_pkg::*;
#(
    parameter int CHIPS       = 2,
    parameter int CH_PER_CHIP = 3,
    parameter int PRE_DIV     = 2,
    parameter int DEC_RATIO   = 10,
    parameter int NUM_DEC     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enh_en,
    input  logic                         wr_en,
    input  logic                         wr_is_gate,
    input  logic [7:0]                   wr_byte,
    input  logic [CHIPS*CH_PER_CHIP-1:0] ext_clk_i,
    input  logic [CHIPS*CH_PER_CHIP-1:0] ext_gate_i,
    output logic [CHIPS*CH_PER_CHIP-1:0] cnt_clk_en_o,
    output logic [CHIPS*CH_PER_CHIP-1:0] cnt_gate_o
);
    localparam int NCH     = CHIPS * CH_PER_CHIP;
    localparam int NUM_DIV = NUM_DEC + 1;

    logic [NUM_DIV-1:0]   div_stb;
    logic [NCH-1:0]       clk_we;
    logic [NCH-1:0]       gate_we;
    src_t                 wr_src;
    logic [NCH*SRC_W-1:0] clk_sel_all;
    logic [NCH*SRC_W-1:0] gate_sel_all;

    srcx_divider #(
        .PRE_DIV   (PRE_DIV),
        .DEC_RATIO (DEC_RATIO),
        .NUM_DEC   (NUM_DEC)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (div_stb)
    );

    srcx_wr_decode #(
        .CHIPS       (CHIPS),
        .CH_PER_CHIP (CH_PER_CHIP)
    ) u_dec (
        .wr_en      (wr_en),
        .wr_is_gate (wr_is_gate),
        .wr_byte    (wr_byte),
        .enh_en     (enh_en),
        .clk_we     (clk_we),
        .gate_we    (gate_we),
        .wr_src     (wr_src)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        srcx_chan #(
            .NUM_DIV (NUM_DIV)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .enh_en   (enh_en),
            .clk_we   (clk_we[i]),
            .gate_we  (gate_we[i]),
            .wr_src   (wr_src),
            .div_stb  (div_stb),
            .ext_clk  (ext_clk_i[i]),
            .ext_gate (ext_gate_i[i]),
            .clk_en   (cnt_clk_en_o[i]),
            .gate     (cnt_gate_o[i]),
            .clk_sel  (clk_sel_all[i*SRC_W +: SRC_W]),
            .gate_sel (gate_sel_all[i*SRC_W +: SRC_W])
        );
    end

endmodule

// File: rtl/srcx_router_chk.sv
module srcx_router_chk #(
    parameter int NCH     = 6,
    parameter int NUM_DIV = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enh_en,
    input logic               wr_en,
    input logic               wr_is_gate,
    input logic [1:0]         wr_chan,
    input logic [NCH*5-1:0]   clk_sel_all,
    input logic [NCH*5-1:0]   gate_sel_all,
    input logic [NUM_DIV-1:0] div_stb,
    input logic [NCH-1:0]     cnt_clk_en_o,
    input logic [NCH-1:0]     cnt_gate_o
);
    logic [NCH-1:0] m_ref;
    logic [NCH-1:0] m_cdead;
    logic [NCH-1:0] m_ghigh;
    logic [NCH-1:0] m_gdead;
    int             hi_cnt;

    always_comb begin
        hi_cnt = 0;
        for (int i = 0; i < NCH; i++) begin
            logic [4:0] cs;
            logic [4:0] gs;
            cs = clk_sel_all[i*5 +: 5];
            gs = gate_sel_all[i*5 +: 5];
            m_ref[i]   = (cs == 5'd11);
            m_cdead[i] = (cs >= 5'd6 && cs != 5'd11) || (cs == 5'd11 && !enh_en);
            m_ghigh[i] = (gs == 5'd0);
            m_gdead[i] = (gs >= 5'd2);
            hi_cnt = hi_cnt + ((cs[4:3] != 2'b00) ? 1 : 0) + ((gs[4:3] != 2'b00) ? 1 : 0);
        end
    end

    AST_BAD_CHAN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_chan == 2'b11) |=> ($stable(clk_sel_all) && $stable(gate_sel_all))); // R3

    AST_BASIC_NO_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !enh_en) |=> (hi_cnt <= $past(hi_cnt))); // R5

    AST_REF_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        enh_en |=> ((cnt_clk_en_o & $past(m_ref)) == $past(m_ref))); // R8

    AST_CLK_DEAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((cnt_clk_en_o & $past(m_cdead)) == '0)); // R10

    AST_GATE_DEAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((cnt_gate_o & $past(m_gdead)) == '0)); // R10

    AST_GATE_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((cnt_gate_o & $past(m_ghigh)) == $past(m_ghigh))); // R9

    AST_FAST_STB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        div_stb[0] |=> !div_stb[0]); // R7

    for (genvar k = 1; k < NUM_DIV; k++) begin : g_nest
        AST_DIV_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
            div_stb[k] |-> div_stb[k-1]); // R7
    end

    AST_CLK_WR_KEEPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_is_gate) |=> $stable(gate_sel_all)); // R11

    AST_GATE_WR_KEEPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_is_gate) |=> $stable(clk_sel_all)); // R11

    AST_IDLE_HOLDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(clk_sel_all) && $stable(gate_sel_all))); // R2

endmodule

bind srcx_router srcx_router_chk #(
    .NCH     (CHIPS*CH_PER_CHIP),
    .NUM_DIV (NUM_DEC+1)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enh_en       (enh_en),
    .wr_en        (wr_en),
    .wr_is_gate   (wr_is_gate),
    .wr_chan      (wr_byte[4:3]),
    .clk_sel_all  (clk_sel_all),
    .gate_sel_all (gate_sel_all),
    .div_stb      (div_stb),
    .cnt_clk_en_o (cnt_clk_en_o),
    .cnt_gate_o   (cnt_gate_o)
);

// File: tb/tb_srcx_router.sv
module tb_srcx_router;

    localparam int NCH = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enh_en = 1'b0;
    logic           wr_en = 1'b0;
    logic           wr_is_gate = 1'b0;
    logic [7:0]     wr_byte = 8'h00;
    logic [NCH-1:0] ext_clk_i = '0;
    logic [NCH-1:0] ext_gate_i = '0;
    logic [NCH-1:0] cnt_clk_en_o;
    logic [NCH-1:0] cnt_gate_o;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        int             due;
        logic [NCH-1:0] mc;
        logic [NCH-1:0] ec;
        logic [NCH-1:0] mg;
        logic [NCH-1:0] eg;
        string          tag;
    } exp_item_t;

    exp_item_t sbq[$];

    srcx_router dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enh_en       (enh_en),
        .wr_en        (wr_en),
        .wr_is_gate   (wr_is_gate),
        .wr_byte      (wr_byte),
        .ext_clk_i    (ext_clk_i),
        .ext_gate_i   (ext_gate_i),
        .cnt_clk_en_o (cnt_clk_en_o),
        .cnt_gate_o   (cnt_gate_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endfunction

    function automatic void push(input int due, input logic [NCH-1:0] mc, input logic [NCH-1:0] ec,
                                 input logic [NCH-1:0] mg, input logic [NCH-1:0] eg, input string tag);
        exp_item_t it;
        it.due = due; it.mc = mc; it.ec = ec; it.mg = mg; it.eg = eg; it.tag = tag;
        sbq.push_back(it);
    endfunction

    // monitor: compares queued expectations one time unit after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                exp_item_t it;
                it = sbq.pop_front();
                if (it.due != cyc)
                    check(1'b0, {it.tag, " stale"}, it.due, cyc);
                if (it.mc != '0)
                    check((cnt_clk_en_o & it.mc) == (it.ec & it.mc), {it.tag, " clk_en"},
                          int'(cnt_clk_en_o & it.mc), int'(it.ec & it.mc));
                if (it.mg != '0)
                    check((cnt_gate_o & it.mg) == (it.eg & it.mg), {it.tag, " gate"},
                          int'(cnt_gate_o & it.mg), int'(it.eg & it.mg));
            end
        end
    end

    task automatic wr_begin(input logic gate_reg, input logic [7:0] b, output int c);
        @(negedge clk);
        wr_en = 1'b1;
        wr_is_gate = gate_reg;
        wr_byte = b;
        c = cyc;
    endtask

    task automatic wr_end();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int ch, input int expv, input string tag);
        int gap = 0;
        bit seen = 1'b0;
        for (int i = 0; i < 2 * expv + 10; i++) begin
            @(posedge clk); #1;
            if (cnt_clk_en_o[ch]) begin seen = 1'b1; break; end
        end
        if (seen) begin
            for (int i = 0; i < 2 * expv + 10; i++) begin
                @(posedge clk); #1;
                gap++;
                if (cnt_clk_en_o[ch]) break;
            end
        end
        check(seen && gap == expv, tag, gap, expv);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int c;
        idle(3);
        rst_n = 1'b1;
        c = cyc;
        // R1: all clock strobes idle and all gates high after reset
        push(c + 1, 6'h3F, 6'h00, 6'h3F, 6'h3F, "R1 reset state");
        push(c + 2, 6'h3F, 6'h00, 6'h3F, 6'h3F, "R1 reset state");
        idle(3);

        // R3: channel field 3 must not reach any channel (ext_gate low exposes a gate hit)
        wr_begin(1'b0, 8'h19, c);
        push(c + 2, 6'h3F, 6'h00, 6'h3F, 6'h3F, "R3 clock write chan=3");
        push(c + 3, 6'h3F, 6'h00, 6'h3F, 6'h3F, "R3 clock write chan=3");
        wr_end();
        wr_begin(1'b1, 8'h19, c);
        push(c + 2, 6'h3F, 6'h00, 6'h3F, 6'h3F, "R3 gate write chan=3");
        push(c + 3, 6'h3F, 6'h00, 6'h3F, 6'h3F, "R3 gate write chan=3");
        wr_end();
        idle(3);

        // R6: pin rising edge on channel 0 gives a single strobe
        ext_clk_i[0] = 1'b1;
        c = cyc;
        push(c + 1, 6'h3F, 6'h01, 6'h00, 6'h00, "R6 pin edge strobe");
        push(c + 2, 6'h3F, 6'h00, 6'h00, 6'h00, "R6 strobe one cycle");
        idle(3);
        ext_clk_i[0] = 1'b0;
        idle(2);

        // R9/R12: channel 3 gate follows its pin (byte chip1 chan0 src1 = 0x21)
        wr_begin(1'b1, 8'h21, c);
        push(c + 1, 6'h00, 6'h00, 6'h3F, 6'h3F, "R12 old gate one cycle after write");
        push(c + 2, 6'h00, 6'h00, 6'h3F, 6'h37, "R9 gate follows pin low");
        wr_end();
        idle(1);
        ext_gate_i[3] = 1'b1;
        c = cyc;
        push(c + 1, 6'h00, 6'h00, 6'h08, 6'h08, "R9 gate follows pin high");
        idle(3);

        // R10: channel 4 gate source 2 and clock source 7 (bytes 0x2A, 0x2F)
        wr_begin(1'b1, 8'h2A, c);
        push(c + 2, 6'h00, 6'h00, 6'h10, 6'h00, "R10 gate source 2 low");
        wr_end();
        wr_begin(1'b0, 8'h2F, c);
        wr_end();
        idle(2);
        ext_clk_i[4] = 1'b1;
        ext_clk_i[3] = 1'b1;
        c = cyc;
        // R11: channel 3 clock still on its pin after the gate write
        push(c + 1, 6'h18, 6'h08, 6'h08, 6'h08, "R10 R11 source 7 silent, pin source kept");
        push(c + 2, 6'h18, 6'h00, 6'h00, 6'h00, "R10 source 7 silent");
        idle(2);
        ext_clk_i[4] = 1'b0;
        ext_clk_i[3] = 1'b0;
        idle(2);

        // R4/R8: extended mode, byte 0x4B -> chip0 chan1 source 11
        enh_en = 1'b1;
        wr_begin(1'b0, 8'h4B, c);
        push(c + 1, 6'h02, 6'h00, 6'h00, 6'h00, "R12 old clock one cycle after write");
        push(c + 2, 6'h02, 6'h02, 6'h00, 6'h00, "R4 R8 source 11 runs");
        push(c + 3, 6'h02, 6'h02, 6'h00, 6'h00, "R8 source 11 every cycle");
        wr_end();
        idle(2);
        enh_en = 1'b0;
        c = cyc;
        push(c + 1, 6'h02, 6'h00, 6'h00, 6'h00, "R8 source 11 stops in basic mode");
        push(c + 2, 6'h02, 6'h00, 6'h00, 6'h00, "R8 source 11 stops in basic mode");
        idle(3);

        // R5: same byte in basic mode stores source 3 (100 kHz, period 200)
        wr_begin(1'b0, 8'h4B, c);
        wr_end();
        measure(1, 200, "R5 R7 basic mode drops high bits");

        // R2/R7: chip1 chan2 source 1 (0x31); other pin-sourced channels stay silent
        wr_begin(1'b0, 8'h31, c);
        push(c + 2, 6'h1D, 6'h00, 6'h20, 6'h20, "R2 only channel 5 changes");
        wr_end();
        measure(5, 2, "R7 source 1 period");
        wr_begin(1'b0, 8'h02, c);
        wr_end();
        measure(0, 20, "R7 source 2 period");
        wr_begin(1'b0, 8'h14, c);
        wr_end();
        measure(2, 2000, "R7 source 4 period");
        wr_begin(1'b0, 8'h15, c);
        wr_end();
        measure(2, 20000, "R7 source 5 period");
        idle(4);
        finish_run();
    end

endmodule